// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block moves one byte over a four-wire serial link as the bus master. A one-cycle `start` pulse in the idle state latches the transmit byte together with three configuration bits: clock polarity, clock phase and bit order. The engine then drops the active-low select line and produces eight serial clock periods. It presents transmit bits on `mosi` and captures `miso` on the edge pair that the chosen mode defines. When the transfer is over it raises the select line, clears `busy` and pulses `done` for one cycle, with the received byte on `rx_byte`.

The serial clock half period is `DIV+1` system clock cycles. `DIV` and the word width `W` are parameters. Modes are numbered from the pair (polarity, phase): 0 = (0,0), 1 = (0,1), 2 = (1,0), 3 = (1,1). In every mode data is launched on one clock edge and captured on the opposite edge.

Top module: `spi_xfer_engine`

## Requirements
- R1: While idle, `sclk` follows the `cpol` input one cycle later (low for 0, high for 1). After the sixteenth edge of a transfer it is back at the captured polarity.
- R2: `ss_n` is low and `busy` is high from the cycle after an accepted `start` until the end of the transfer. At all other times `ss_n` is high and `busy` is low.
- R3: The first `sclk` edge comes `DIV+1` cycles after `ss_n` falls. Each following edge comes `DIV+1` cycles after the one before. Exactly 16 edges occur, and `ss_n` rises `DIV+1` cycles after the last edge, 17*(DIV+1) cycles after the accepting edge.
- R4: The leading (odd-numbered) edge samples and the trailing edge sets up when `cpha`=0. When `cpha`=1 the leading edge sets up and the trailing edge samples. So mode 0 samples on rising edges, mode 2 on falling edges, mode 1 on falling edges and mode 3 on rising edges. `mosi` changes only together with an `sclk` edge.
- R5: With `cpha`=0, the first data bit is on `mosi` in the same cycle that `ss_n` first reads low, before any `sclk` edge.
- R6: With `lsb_first`=0, bit 7 is sent first and bit 0 last. With `lsb_first`=1, bit 0 is sent first. The received byte is assembled in the same order, so the first bit received lands in bit 7 or bit 0 respectively.
- R7: `done` is high for exactly one cycle, in the same cycle that `ss_n` rises and `busy` falls. `rx_byte` holds the received byte from that cycle on.
- R8: A `start` pulse while `busy` is high is ignored. The running transfer keeps its transmit byte, its edge count and its timing.
- R9: `cpol`, `cpha` and `lsb_first` are captured when `start` is accepted. Changing them during a transfer has no effect on that transfer.
- R10: After reset `ss_n`=1, `busy`=0, `done`=0, `sclk`=0 and `rx_byte`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (acted on only when idle) |
| tx_byte | input | W | Byte to transmit |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first | input | 1 | 0: most significant bit first; 1: least significant first |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_byte | output | W | Received byte |

## Verification
Some properties are checked on every cycle:
- spacing of select and clock transitions by exactly `DIV+1` cycles;
- `ss_n` as the inverse of `busy`;
- `mosi` holding still between clock edges;
- the single-cycle `done` coinciding with select release;
- the idle clock following `cpol`;
- the first bit being valid at select fall in phase 0.

Other properties only the directed scenarios can show. These are the edge count, bit order on both wires, and the correct sample edge for each of the four modes. They also include that a stray `start` or configuration change mid-transfer leaves the result untouched. The bench proves these with a slave model that drives and captures data on the edges each mode defines.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_t;

  typedef struct packed {
    logic pol;
    logic pha;
    logic lsb;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 0) ? $clog2(DIV + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(DIV);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] tx_in,
  input  logic         lsb,
  input  logic         tx_step,
  input  logic         rx_step,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_sr;
  logic [W-1:0] rx_sr;

  assign mosi    = lsb ? tx_sr[0] : tx_sr[W-1];
  assign rx_word = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
    end else if (load) begin
      tx_sr <= tx_in;
    end else if (tx_step) begin
      tx_sr <= lsb ? (tx_sr >> 1) : (tx_sr << 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sr <= '0;
    end else if (rx_step) begin
      rx_sr <= lsb ? {miso, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso};
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int W   = 8,
  parameter int DIV = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_byte,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         ss_n,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int NEDGE = 2 * W;
  localparam int ECW   = $clog2(NEDGE + 1);
  localparam logic [ECW-1:0] LAST_EDGE = ECW'(NEDGE);

  xfer_state_t    state;
  xfer_cfg_t      cfg_q;
  logic [ECW-1:0] edge_cnt;
  logic           sclk_r, ss_n_r, busy_r, done_r;
  logic [W-1:0]   rx_q;
  logic [W-1:0]   rx_word;

  logic tick, accept, edge_evt, leading, sample_evt, setup_evt;

  // Half-period timebase runs only while a transfer is active.
  spi_half_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (state == ST_RUN),
    .tick(tick)
  );

  // Edge classification: phase 0 samples on leading edges, phase 1 on
  // trailing ones; the first leading edge in phase 1 has its bit preloaded.
  always_comb begin
    accept     = (state == ST_IDLE) && start;
    edge_evt   = tick && (edge_cnt != LAST_EDGE);
    leading    = !edge_cnt[0];
    sample_evt = edge_evt && (leading ^ cfg_q.pha);
    setup_evt  = edge_evt && !(leading ^ cfg_q.pha) &&
                 !(cfg_q.pha && (edge_cnt == '0));
  end

  spi_shift_unit #(.W(W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .tx_in  (tx_byte),
    .lsb    (cfg_q.lsb),
    .tx_step(setup_evt),
    .rx_step(sample_evt),
    .miso   (miso),
    .mosi   (mosi),
    .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cfg_q    <= '0;
      edge_cnt <= '0;
      sclk_r   <= 1'b0;
      ss_n_r   <= 1'b1;
      busy_r   <= 1'b0;
      done_r   <= 1'b0;
      rx_q     <= '0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclk_r   <= cpol;
          edge_cnt <= '0;
          if (start) begin
            cfg_q  <= '{pol: cpol, pha: cpha, lsb: lsb_first};
            state  <= ST_RUN;
            ss_n_r <= 1'b0;
            busy_r <= 1'b1;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (edge_cnt == LAST_EDGE) begin
              state  <= ST_IDLE;
              ss_n_r <= 1'b1;
              busy_r <= 1'b0;
              done_r <= 1'b1;
              rx_q   <= rx_word;
            end else begin
              sclk_r   <= ~sclk_r;
              edge_cnt <= edge_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign sclk    = sclk_r;
  assign ss_n    = ss_n_r;
  assign busy    = busy_r;
  assign done    = done_r;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int DIV = 3
) (
  input logic clk,
  input logic rst,
  input logic cpol,
  input logic cpha,
  input logic tx_first,
  input logic sclk,
  input logic mosi,
  input logic ss_n,
  input logic busy,
  input logic done
);
  logic        sclk_d, ssn_d;
  logic [31:0] gap;
  logic        chg;

  assign chg = (sclk != sclk_d) || (ss_n != ssn_d);

  // Cycles since the last transition of sclk or ss_n.
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      ssn_d  <= 1'b1;
      gap    <= '0;
    end else begin
      sclk_d <= sclk;
      ssn_d  <= ss_n;
      if (chg) gap <= 32'd1;
      else if (gap != 32'hFFFF_FFFF) gap <= gap + 32'd1;
    end
  end

  assert_edge_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (chg && !ssn_d) |-> (gap == 32'(DIV + 1)));

  assert_select_busy_R2: assert property (@(posedge clk) disable iff (rst)
    ss_n == !busy);

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $past(!rst)) |-> (sclk == $past(cpol)));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && $past(!ss_n) && $stable(sclk)) |-> $stable(mosi));

  assert_first_bit_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ss_n) && $past(!cpha)) |-> (mosi == $past(tx_first)));

  assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (ss_n && !busy && $past(busy)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.DIV(DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cpol    (cpol),
  .cpha    (cpha),
  .tx_first(lsb_first ? tx_byte[0] : tx_byte[W-1]),
  .sclk    (sclk),
  .mosi    (mosi),
  .ss_n    (ss_n),
  .busy    (busy),
  .done    (done)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;
  localparam int W   = 8;
  localparam int DIV = 2;
  localparam int H   = DIV + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] tx_byte = '0;
  logic cpol = 1'b0, cpha = 1'b0, lsb_first = 1'b0, miso = 1'b0;
  logic sclk, mosi, ss_n, busy, done;
  logic [W-1:0] rx_byte;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  spi_xfer_engine #(.W(W), .DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
    .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .miso(miso),
    .sclk(sclk), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done),
    .rx_byte(rx_byte)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bit position of the i-th transmitted bit for a given order.
  function automatic int pos_of(input int i, input bit lsb);
    return lsb ? i : (W - 1 - i);
  endfunction

  task automatic run_xfer(input bit pol, input bit pha, input bit lsb,
                          input logic [W-1:0] tx, input logic [W-1:0] sb,
                          input bit poke);
    int n, edges, sbit, mbit, tim_err, glitch;
    logic [W-1:0] mcap;
    logic prev_sclk, prev_mosi;
    cpol = pol; cpha = pha; lsb_first = lsb; tx_byte = tx;
    miso = pha ? ~sb[pos_of(0, lsb)] : sb[pos_of(0, lsb)];
    @(negedge clk);
    check(sclk == pol && ss_n == 1'b1, "R1 idle sclk", sclk, pol);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; edges = 0; mbit = 0; tim_err = 0; glitch = 0; mcap = '0;
    sbit = pha ? 0 : 1;
    check(ss_n == 1'b0 && busy == 1'b1, "R2 select low and busy", {ss_n, busy}, 2'b01);
    if (!pha) check(mosi == tx[pos_of(0, lsb)], "R5 first bit before edge", mosi, tx[pos_of(0, lsb)]);
    prev_sclk = sclk; prev_mosi = mosi;
    while (!done && n < 20 * H) begin
      @(negedge clk);
      n++;
      if (poke && n == 5 * H + 1) begin
        start = 1'b1; tx_byte = ~tx; cpol = ~pol; cpha = ~pha; lsb_first = ~lsb;
      end
      if (poke && n == 5 * H + 2) begin
        start = 1'b0; tx_byte = tx; cpol = pol; cpha = pha; lsb_first = lsb;
      end
      if (done) break;
      if (ss_n != 1'b0 || busy != 1'b1) tim_err++;
      if (sclk != prev_sclk) begin
        if (n != (edges + 1) * H) tim_err++;
        if (((edges % 2) == 0) ^ pha) begin
          if (mbit < W) mcap[pos_of(mbit, lsb)] = mosi;
          mbit++;
        end else begin
          if (sbit < W) miso = sb[pos_of(sbit, lsb)];
          sbit++;
        end
        edges++;
      end else if (mosi != prev_mosi) begin
        glitch++;
      end
      prev_sclk = sclk; prev_mosi = mosi;
    end
    check(done == 1'b1 && n == 17 * H, "R3 transfer length", n, 17 * H);
    check(edges == 2 * W, "R3 edge count", edges, 2 * W);
    check(tim_err == 0, "R3 edge spacing and select hold", tim_err, 0);
    check(glitch == 0, "R4 mosi moves only on edges", glitch, 0);
    check(mcap == tx, "R4 R6 transmitted byte", mcap, tx);
    check(rx_byte == sb, "R4 R6 received byte", rx_byte, sb);
    check(ss_n == 1'b1 && busy == 1'b0, "R7 release with done", {ss_n, busy}, 2'b10);
    check(sclk == pol, "R1 clock back at idle", sclk, pol);
    @(negedge clk);
    check(done == 1'b0, "R7 done lasts one cycle", done, 0);
    check(busy == 1'b0 && ss_n == 1'b1, "R8 no restart from ignored start", {ss_n, busy}, 2'b10);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(ss_n == 1'b1 && busy == 1'b0 && done == 1'b0, "R10 control outputs",
          {ss_n, busy, done}, 3'b100);
    check(sclk == 1'b0 && rx_byte == '0, "R10 clock and data", {sclk, rx_byte}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_idle_level();
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R1 idle follows cpol=1", sclk, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    check(sclk == 1'b0, "R1 idle follows cpol=0", sclk, 0);
  endtask

  task automatic test_modes_msb();
    run_xfer(1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0);
    run_xfer(1'b0, 1'b1, 1'b0, 8'h81, 8'hE7, 1'b0);
    run_xfer(1'b1, 1'b0, 1'b0, 8'h5A, 8'h96, 1'b0);
    run_xfer(1'b1, 1'b1, 1'b0, 8'hF0, 8'h0F, 1'b0);
  endtask

  task automatic test_lsb_first();
    run_xfer(1'b0, 1'b0, 1'b1, 8'h01, 8'h80, 1'b0);
    run_xfer(1'b0, 1'b1, 1'b1, 8'hC3, 8'h2D, 1'b0);
    run_xfer(1'b1, 1'b0, 1'b1, 8'h6E, 8'hB1, 1'b0);
  endtask

  task automatic test_busy_ignore();
    // R8 stray start and R9 configuration change mid-transfer.
    run_xfer(1'b1, 1'b1, 1'b1, 8'h37, 8'hD4, 1'b1);
    run_xfer(1'b0, 1'b0, 1'b0, 8'h9B, 8'h62, 1'b1);
  endtask

  initial begin
    test_reset();
    test_idle_level();
    test_modes_msb();
    test_lsb_first();
    test_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule